// File: doc/BRIEF.md
# Bridge Upstream Request Gate

This block sits on the upstream path of a bridge port. Requests from the secondary side arrive on a valid/ready channel carrying a kind, address, byte enables, data and a tag. One register stage later they leave on the primary side. A bus master enable input sets whether a request passes untouched or is neutralised. Neutralised requests are not dropped. A write still travels upstream, but its address and byte enables are zeroed. A read still travels upstream at address zero, and the block itself answers it with an Unsupported Request completion that carries the original tag.

Completions coming back from the primary side go to the secondary side unchanged, whatever the enable says. They share one registered completion output with the locally built Unsupported Request answers. Returning traffic has priority, and local answers wait in a small tag queue.

A separate decode path checks downstream addresses against one memory window, one prefetchable memory window and one I/O window. The memory enable gates the two memory windows and the I/O enable gates the I/O window.

Top module: `upgate_bridge`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `pr_valid_o`, `sc_valid_o`, `dn_mem_hit_o` and `dn_io_hit_o` are 0.
- R2: With `bme_i`=0, an accepted write leaves with address 0, all byte enables 0 and `pr_blocked_o`=1. Its kind, data, tag and message flag are unchanged. No local completion is made for it. Kind encoding: 00 memory read, 01 memory write, 10 I/O read, 11 I/O write.
- R3: With `bme_i`=0, an accepted read (kind 00 or 10) leaves with address 0, its byte enables unchanged and `pr_blocked_o`=1. A completion with status 001 (Unsupported Request), data 0 and the original tag is later presented on the secondary completion output.
- R4: A message-signalled interrupt (`rq_msi_i`=1 on kind 01) is treated exactly like any other memory write, and its flag is carried through.
- R5: With `bme_i`=1, an accepted request leaves with every field unchanged and `pr_blocked_o`=0, and no local completion is made.
- R6: A request is taken when `rq_valid_i` and `rq_ready_o` are both 1. The primary output shows it in the next cycle. `rq_ready_o` is 1 exactly when the output stage is empty or being accepted and the local completion queue is not full. Back-to-back requests flow one per cycle. A stalled output holds its value.
- R7: A primary completion is copied to the secondary output (tag, status, data) one cycle after it is taken, whatever the value of `bme_i`. `pc_ready_o` is 1 when the completion output is empty or being accepted. Status 000 means successful.
- R8: When a primary completion and a queued local completion compete for a free completion output, the primary one goes first. Local completions leave in the order their reads were accepted.
- R9: `dn_mem_hit_o` is 1 one cycle after `dn_addr_i` lies inclusively between either memory base and limit pair while `mae_i`=1, and it is 0 whenever `mae_i` was 0.
- R10: `dn_io_hit_o` is 1 one cycle after `dn_io_addr_i` lies inclusively between the I/O base and limit while `ioae_i`=1, and it is 0 whenever `ioae_i` was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bme_i | input | 1 | Upstream mastering enable |
| mae_i | input | 1 | Memory window enable |
| ioae_i | input | 1 | I/O window enable |
| mem_base_i | input | ADDR_W | Memory window base |
| mem_limit_i | input | ADDR_W | Memory window limit |
| pmem_base_i | input | ADDR_W | Prefetchable window base |
| pmem_limit_i | input | ADDR_W | Prefetchable window limit |
| io_base_i | input | IO_W | I/O window base |
| io_limit_i | input | IO_W | I/O window limit |
| dn_addr_i | input | ADDR_W | Downstream memory address to decode |
| dn_io_addr_i | input | IO_W | Downstream I/O address to decode |
| dn_mem_hit_o | output | 1 | Registered memory window hit |
| dn_io_hit_o | output | 1 | Registered I/O window hit |
| rq_valid_i | input | 1 | Secondary request valid |
| rq_ready_o | output | 1 | Secondary request ready |
| rq_type_i | input | 2 | Request kind |
| rq_msi_i | input | 1 | Interrupt message flag |
| rq_addr_i | input | ADDR_W | Request address |
| rq_be_i | input | DATA_W/8 | Request byte enables |
| rq_data_i | input | DATA_W | Request write data |
| rq_tag_i | input | TAG_W | Request tag |
| pr_valid_o | output | 1 | Primary request valid |
| pr_ready_i | input | 1 | Primary request ready |
| pr_type_o | output | 2 | Forwarded kind |
| pr_msi_o | output | 1 | Forwarded message flag |
| pr_addr_o | output | ADDR_W | Forwarded address |
| pr_be_o | output | DATA_W/8 | Forwarded byte enables |
| pr_data_o | output | DATA_W | Forwarded data |
| pr_tag_o | output | TAG_W | Forwarded tag |
| pr_blocked_o | output | 1 | Request was neutralised |
| pc_valid_i | input | 1 | Primary completion valid |
| pc_ready_o | output | 1 | Primary completion ready |
| pc_tag_i | input | TAG_W | Primary completion tag |
| pc_status_i | input | 3 | Primary completion status |
| pc_data_i | input | DATA_W | Primary completion data |
| sc_valid_o | output | 1 | Secondary completion valid |
| sc_ready_i | input | 1 | Secondary completion ready |
| sc_tag_o | output | TAG_W | Secondary completion tag |
| sc_status_o | output | 3 | Secondary completion status |
| sc_data_o | output | DATA_W | Secondary completion data |

## Verification
The two functions that can collide are the forwarding of a returning primary completion and the issue of a queued Unsupported Request answer. Both target the one completion output. To provoke the collision, reads are sent while mastering is off and the secondary side is held not ready, so answers pile up in the queue. Then the secondary side is released in the same cycle that primary completions start arriving. The bench's behavioural queue model predicts the exact order on every clock: primary traffic first, then local answers in acceptance order. Any deviation in valid, tag or status is reported.

// File: rtl/upgate_pkg.sv
`timescale 1ns/1ps
package upgate_pkg;
  typedef enum logic [1:0] {
    RQ_MRD  = 2'b00,
    RQ_MWR  = 2'b01,
    RQ_IORD = 2'b10,
    RQ_IOWR = 2'b11
  } rq_kind_e;

  localparam logic [2:0] CS_OK = 3'b000;
  localparam logic [2:0] CS_UR = 3'b001;
endpackage

// File: rtl/upgate_rewrite.sv
`timescale 1ns/1ps
// Combinational neutralisation of a secondary request under the mastering enable.
module upgate_rewrite #(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 4
) (
  input  logic              bme_i,
  input  logic              is_write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BE_W-1:0]   be_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BE_W-1:0]   be_o,
  output logic              blocked_o,
  output logic              need_ur_o
);
  always_comb begin
    blocked_o = !bme_i;
    need_ur_o = !bme_i && !is_write_i;
    addr_o    = bme_i ? addr_i : '0;
    be_o      = (!bme_i && is_write_i) ? '0 : be_i;
  end
endmodule

// File: rtl/upgate_tag_fifo.sv
`timescale 1ns/1ps
// Small tag queue for locally answered reads. DEPTH must be a power of two, at least 2.
module upgate_tag_fifo #(
  parameter int TAG_W = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic [TAG_W-1:0] push_tag_i,
  input  logic             pop_i,
  output logic [TAG_W-1:0] head_tag_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [TAG_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  assign empty_o    = (count == '0);
  assign full_o     = (count == CNT_W'(DEPTH));
  assign head_tag_o = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_i) mem[wr_ptr] <= push_tag_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_i) wr_ptr <= wr_ptr + 1'b1;
      if (pop_i)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_i, pop_i})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/upgate_window.sv
`timescale 1ns/1ps
// Registered downstream window decode for memory, prefetchable memory and I/O ranges.
module upgate_window #(
  parameter int ADDR_W = 32,
  parameter int IO_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mae_i,
  input  logic              ioae_i,
  input  logic [ADDR_W-1:0] mem_base_i,
  input  logic [ADDR_W-1:0] mem_limit_i,
  input  logic [ADDR_W-1:0] pmem_base_i,
  input  logic [ADDR_W-1:0] pmem_limit_i,
  input  logic [IO_W-1:0]   io_base_i,
  input  logic [IO_W-1:0]   io_limit_i,
  input  logic [ADDR_W-1:0] dn_addr_i,
  input  logic [IO_W-1:0]   dn_io_addr_i,
  output logic              mem_hit_o,
  output logic              io_hit_o
);
  logic in_mem, in_pmem, in_io;

  always_comb begin
    in_mem  = (dn_addr_i >= mem_base_i)  && (dn_addr_i <= mem_limit_i);
    in_pmem = (dn_addr_i >= pmem_base_i) && (dn_addr_i <= pmem_limit_i);
    in_io   = (dn_io_addr_i >= io_base_i) && (dn_io_addr_i <= io_limit_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_hit_o <= 1'b0;
      io_hit_o  <= 1'b0;
    end else begin
      mem_hit_o <= mae_i && (in_mem || in_pmem);
      io_hit_o  <= ioae_i && in_io;
    end
  end
endmodule

// File: rtl/upgate_bridge.sv
`timescale 1ns/1ps
module upgate_bridge
  import upgate_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 8,
  parameter int IO_W     = 16,
  parameter int UR_DEPTH = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bme_i,
  input  logic                  mae_i,
  input  logic                  ioae_i,
  input  logic [ADDR_W-1:0]     mem_base_i,
  input  logic [ADDR_W-1:0]     mem_limit_i,
  input  logic [ADDR_W-1:0]     pmem_base_i,
  input  logic [ADDR_W-1:0]     pmem_limit_i,
  input  logic [IO_W-1:0]       io_base_i,
  input  logic [IO_W-1:0]       io_limit_i,
  input  logic [ADDR_W-1:0]     dn_addr_i,
  input  logic [IO_W-1:0]       dn_io_addr_i,
  output logic                  dn_mem_hit_o,
  output logic                  dn_io_hit_o,
  input  logic                  rq_valid_i,
  output logic                  rq_ready_o,
  input  logic [1:0]            rq_type_i,
  input  logic                  rq_msi_i,
  input  logic [ADDR_W-1:0]     rq_addr_i,
  input  logic [DATA_W/8-1:0]   rq_be_i,
  input  logic [DATA_W-1:0]     rq_data_i,
  input  logic [TAG_W-1:0]      rq_tag_i,
  output logic                  pr_valid_o,
  input  logic                  pr_ready_i,
  output logic [1:0]            pr_type_o,
  output logic                  pr_msi_o,
  output logic [ADDR_W-1:0]     pr_addr_o,
  output logic [DATA_W/8-1:0]   pr_be_o,
  output logic [DATA_W-1:0]     pr_data_o,
  output logic [TAG_W-1:0]      pr_tag_o,
  output logic                  pr_blocked_o,
  input  logic                  pc_valid_i,
  output logic                  pc_ready_o,
  input  logic [TAG_W-1:0]      pc_tag_i,
  input  logic [2:0]            pc_status_i,
  input  logic [DATA_W-1:0]     pc_data_i,
  output logic                  sc_valid_o,
  input  logic                  sc_ready_i,
  output logic [TAG_W-1:0]      sc_tag_o,
  output logic [2:0]            sc_status_o,
  output logic [DATA_W-1:0]     sc_data_o
);
  localparam int BE_W = DATA_W / 8;

  logic              pr_free, sc_free, take_rq, ur_pop;
  logic              ur_full, ur_empty;
  logic [TAG_W-1:0]  ur_head;
  logic [ADDR_W-1:0] rw_addr;
  logic [BE_W-1:0]   rw_be;
  logic              rw_blocked, rw_need_ur;

  upgate_rewrite #(.ADDR_W(ADDR_W), .BE_W(BE_W)) rewrite_i (
    .bme_i      (bme_i),
    .is_write_i (rq_type_i[0]),
    .addr_i     (rq_addr_i),
    .be_i       (rq_be_i),
    .addr_o     (rw_addr),
    .be_o       (rw_be),
    .blocked_o  (rw_blocked),
    .need_ur_o  (rw_need_ur)
  );

  // Request stage: full throughput, stalls only on primary backpressure or a full answer queue.
  assign pr_free    = !pr_valid_o || pr_ready_i;
  assign rq_ready_o = pr_free && !ur_full;
  assign take_rq    = rq_valid_i && rq_ready_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      pr_valid_o   <= 1'b0;
      pr_type_o    <= RQ_MRD;
      pr_msi_o     <= 1'b0;
      pr_addr_o    <= '0;
      pr_be_o      <= '0;
      pr_data_o    <= '0;
      pr_tag_o     <= '0;
      pr_blocked_o <= 1'b0;
    end else if (pr_free) begin
      pr_valid_o <= take_rq;
      if (take_rq) begin
        pr_type_o    <= rq_type_i;
        pr_msi_o     <= rq_msi_i;
        pr_addr_o    <= rw_addr;
        pr_be_o      <= rw_be;
        pr_data_o    <= rq_data_i;
        pr_tag_o     <= rq_tag_i;
        pr_blocked_o <= rw_blocked;
      end
    end
  end

  upgate_tag_fifo #(.TAG_W(TAG_W), .DEPTH(UR_DEPTH)) urq_i (
    .clk        (clk),
    .rst        (rst),
    .push_i     (take_rq && rw_need_ur),
    .push_tag_i (rq_tag_i),
    .pop_i      (ur_pop),
    .head_tag_o (ur_head),
    .empty_o    (ur_empty),
    .full_o     (ur_full)
  );

  // Completion stage: returning primary traffic wins over local answers.
  assign sc_free    = !sc_valid_o || sc_ready_i;
  assign pc_ready_o = sc_free;
  assign ur_pop     = sc_free && !pc_valid_i && !ur_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      sc_valid_o  <= 1'b0;
      sc_tag_o    <= '0;
      sc_status_o <= CS_OK;
      sc_data_o   <= '0;
    end else if (sc_free) begin
      sc_valid_o <= pc_valid_i || !ur_empty;
      if (pc_valid_i) begin
        sc_tag_o    <= pc_tag_i;
        sc_status_o <= pc_status_i;
        sc_data_o   <= pc_data_i;
      end else if (!ur_empty) begin
        sc_tag_o    <= ur_head;
        sc_status_o <= CS_UR;
        sc_data_o   <= '0;
      end
    end
  end

  upgate_window #(.ADDR_W(ADDR_W), .IO_W(IO_W)) window_i (
    .clk          (clk),
    .rst          (rst),
    .mae_i        (mae_i),
    .ioae_i       (ioae_i),
    .mem_base_i   (mem_base_i),
    .mem_limit_i  (mem_limit_i),
    .pmem_base_i  (pmem_base_i),
    .pmem_limit_i (pmem_limit_i),
    .io_base_i    (io_base_i),
    .io_limit_i   (io_limit_i),
    .dn_addr_i    (dn_addr_i),
    .dn_io_addr_i (dn_io_addr_i),
    .mem_hit_o    (dn_mem_hit_o),
    .io_hit_o     (dn_io_hit_o)
  );
endmodule

// File: rtl/upgate_bridge_chk.sv
`timescale 1ns/1ps
module upgate_bridge_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                bme_i,
  input logic                mae_i,
  input logic                ioae_i,
  input logic                rq_valid_i,
  input logic                rq_ready_o,
  input logic [ADDR_W-1:0]   rq_addr_i,
  input logic                pr_valid_o,
  input logic                pr_ready_i,
  input logic [1:0]          pr_type_o,
  input logic [ADDR_W-1:0]   pr_addr_o,
  input logic [DATA_W/8-1:0] pr_be_o,
  input logic [TAG_W-1:0]    pr_tag_o,
  input logic                pr_blocked_o,
  input logic                pc_valid_i,
  input logic                pc_ready_o,
  input logic [TAG_W-1:0]    pc_tag_i,
  input logic [2:0]          pc_status_i,
  input logic                sc_valid_o,
  input logic                sc_ready_i,
  input logic [TAG_W-1:0]    sc_tag_o,
  input logic [2:0]          sc_status_o,
  input logic                dn_mem_hit_o,
  input logic                dn_io_hit_o
);
  // R2: a neutralised write carries neither address nor byte enables
  a_r2_write_zeroed: assert property (@(posedge clk) disable iff (rst)
    (pr_valid_o && pr_blocked_o && (pr_type_o == 2'b01 || pr_type_o == 2'b11))
      |-> (pr_addr_o == '0 && pr_be_o == '0));

  // R5: with mastering on, the address goes through untouched
  a_r5_pass_addr: assert property (@(posedge clk) disable iff (rst)
    (rq_valid_i && rq_ready_o && bme_i)
      |=> (pr_valid_o && !pr_blocked_o && pr_addr_o == $past(rq_addr_i)));

  // R6: a stalled primary request holds its value
  a_r6_pr_hold: assert property (@(posedge clk) disable iff (rst)
    (pr_valid_o && !pr_ready_i)
      |=> (pr_valid_o && $stable(pr_addr_o) && $stable(pr_tag_o) && $stable(pr_blocked_o)));

  // R7: a taken primary completion appears next cycle on the secondary side
  a_r7_pc_through: assert property (@(posedge clk) disable iff (rst)
    (pc_valid_i && pc_ready_o)
      |=> (sc_valid_o && sc_tag_o == $past(pc_tag_i) && sc_status_o == $past(pc_status_i)));

  // R8: a stalled completion holds its value
  a_r8_sc_hold: assert property (@(posedge clk) disable iff (rst)
    (sc_valid_o && !sc_ready_i)
      |=> (sc_valid_o && $stable(sc_tag_o) && $stable(sc_status_o)));

  // R9: closed memory windows never hit
  a_r9_mem_closed: assert property (@(posedge clk) disable iff (rst)
    !mae_i |=> !dn_mem_hit_o);

  // R10: closed I/O window never hits
  a_r10_io_closed: assert property (@(posedge clk) disable iff (rst)
    !ioae_i |=> !dn_io_hit_o);
endmodule

bind upgate_bridge upgate_bridge_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .bme_i        (bme_i),
  .mae_i        (mae_i),
  .ioae_i       (ioae_i),
  .rq_valid_i   (rq_valid_i),
  .rq_ready_o   (rq_ready_o),
  .rq_addr_i    (rq_addr_i),
  .pr_valid_o   (pr_valid_o),
  .pr_ready_i   (pr_ready_i),
  .pr_type_o    (pr_type_o),
  .pr_addr_o    (pr_addr_o),
  .pr_be_o      (pr_be_o),
  .pr_tag_o     (pr_tag_o),
  .pr_blocked_o (pr_blocked_o),
  .pc_valid_i   (pc_valid_i),
  .pc_ready_o   (pc_ready_o),
  .pc_tag_i     (pc_tag_i),
  .pc_status_i  (pc_status_i),
  .sc_valid_o   (sc_valid_o),
  .sc_ready_i   (sc_ready_i),
  .sc_tag_o     (sc_tag_o),
  .sc_status_o  (sc_status_o),
  .dn_mem_hit_o (dn_mem_hit_o),
  .dn_io_hit_o  (dn_io_hit_o)
);

// File: tb/upgate_bridge_tb_top.sv
`timescale 1ns/1ps
module upgate_bridge_tb_top;
  localparam int ADDR_W   = 32;
  localparam int DATA_W   = 32;
  localparam int BE_W     = DATA_W / 8;
  localparam int TAG_W    = 8;
  localparam int IO_W     = 16;
  localparam int UR_DEPTH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic bme, mae, ioae;
  logic [ADDR_W-1:0] mem_base, mem_limit, pmem_base, pmem_limit, dn_addr;
  logic [IO_W-1:0]   io_base, io_limit, dn_io_addr;
  logic dn_mem_hit, dn_io_hit;
  logic rq_valid, rq_ready, rq_msi;
  logic [1:0] rq_type;
  logic [ADDR_W-1:0] rq_addr;
  logic [BE_W-1:0] rq_be;
  logic [DATA_W-1:0] rq_data;
  logic [TAG_W-1:0] rq_tag;
  logic pr_valid, pr_ready, pr_msi, pr_blocked;
  logic [1:0] pr_type;
  logic [ADDR_W-1:0] pr_addr;
  logic [BE_W-1:0] pr_be;
  logic [DATA_W-1:0] pr_data;
  logic [TAG_W-1:0] pr_tag;
  logic pc_valid, pc_ready;
  logic [TAG_W-1:0] pc_tag;
  logic [2:0] pc_status;
  logic [DATA_W-1:0] pc_data;
  logic sc_valid, sc_ready;
  logic [TAG_W-1:0] sc_tag;
  logic [2:0] sc_status;
  logic [DATA_W-1:0] sc_data;

  upgate_bridge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .IO_W(IO_W),
                  .UR_DEPTH(UR_DEPTH)) dut_i (
    .clk(clk), .rst(rst), .bme_i(bme), .mae_i(mae), .ioae_i(ioae),
    .mem_base_i(mem_base), .mem_limit_i(mem_limit),
    .pmem_base_i(pmem_base), .pmem_limit_i(pmem_limit),
    .io_base_i(io_base), .io_limit_i(io_limit),
    .dn_addr_i(dn_addr), .dn_io_addr_i(dn_io_addr),
    .dn_mem_hit_o(dn_mem_hit), .dn_io_hit_o(dn_io_hit),
    .rq_valid_i(rq_valid), .rq_ready_o(rq_ready), .rq_type_i(rq_type),
    .rq_msi_i(rq_msi), .rq_addr_i(rq_addr), .rq_be_i(rq_be),
    .rq_data_i(rq_data), .rq_tag_i(rq_tag),
    .pr_valid_o(pr_valid), .pr_ready_i(pr_ready), .pr_type_o(pr_type),
    .pr_msi_o(pr_msi), .pr_addr_o(pr_addr), .pr_be_o(pr_be),
    .pr_data_o(pr_data), .pr_tag_o(pr_tag), .pr_blocked_o(pr_blocked),
    .pc_valid_i(pc_valid), .pc_ready_o(pc_ready), .pc_tag_i(pc_tag),
    .pc_status_i(pc_status), .pc_data_i(pc_data),
    .sc_valid_o(sc_valid), .sc_ready_i(sc_ready), .sc_tag_o(sc_tag),
    .sc_status_o(sc_status), .sc_data_o(sc_data)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  bit m_pv, m_msi, m_blk;
  logic [1:0] m_ty;
  logic [ADDR_W-1:0] m_addr;
  logic [BE_W-1:0] m_be;
  logic [DATA_W-1:0] m_data;
  logic [TAG_W-1:0] m_tag;
  string m_req;
  bit m_sv;
  logic [TAG_W-1:0] m_stag;
  logic [2:0] m_sst;
  logic [DATA_W-1:0] m_sdat;
  string m_sreq;
  int ur_q[$];
  bit m_mh, m_ih;

  bit pfree, sfree, acc;

  always @(posedge clk) begin
    if (rst) begin
      m_pv = 0; m_sv = 0; m_mh = 0; m_ih = 0;
      ur_q.delete();
    end else begin
      pfree = !m_pv || pr_ready;
      sfree = !m_sv || sc_ready;
      acc   = rq_valid && pfree && (ur_q.size() < UR_DEPTH);
      if (sfree) begin
        if (pc_valid) begin
          m_sv = 1; m_stag = pc_tag; m_sst = pc_status; m_sdat = pc_data; m_sreq = "R7";
        end else if (ur_q.size() > 0) begin
          m_sv = 1; m_stag = TAG_W'(ur_q.pop_front()); m_sst = 3'b001; m_sdat = '0;
          m_sreq = "R3";
        end else m_sv = 0;
      end
      if (pfree) begin
        m_pv = acc;
        if (acc) begin
          m_ty = rq_type; m_msi = rq_msi; m_data = rq_data; m_tag = rq_tag;
          m_blk = !bme;
          m_addr = bme ? rq_addr : '0;
          m_be = (!bme && rq_type[0]) ? '0 : rq_be;
          if (bme) m_req = "R5";
          else if (rq_msi) m_req = "R4";
          else if (rq_type[0]) m_req = "R2";
          else m_req = "R3";
        end
      end
      if (acc && !bme && !rq_type[0]) ur_q.push_back(int'(rq_tag));
      m_mh = mae && ((dn_addr >= mem_base && dn_addr <= mem_limit) ||
                     (dn_addr >= pmem_base && dn_addr <= pmem_limit));
      m_ih = ioae && (dn_io_addr >= io_base && dn_io_addr <= io_limit);
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(rq_ready == ((!m_pv || pr_ready) && (ur_q.size() < UR_DEPTH)), "R6", "rq_ready",
          64'(rq_ready), 64'((!m_pv || pr_ready) && (ur_q.size() < UR_DEPTH)));
      chk(pc_ready == (!m_sv || sc_ready), "R7", "pc_ready", 64'(pc_ready),
          64'(!m_sv || sc_ready));
      chk(pr_valid == m_pv, "R6", "pr_valid", 64'(pr_valid), 64'(m_pv));
      if (m_pv) begin
        chk(pr_addr == m_addr, m_req, "pr_addr", 64'(pr_addr), 64'(m_addr));
        chk(pr_be == m_be, m_req, "pr_be", 64'(pr_be), 64'(m_be));
        chk(pr_blocked == m_blk, m_req, "pr_blocked", 64'(pr_blocked), 64'(m_blk));
        chk(pr_type == m_ty, m_req, "pr_type", 64'(pr_type), 64'(m_ty));
        chk(pr_msi == m_msi, m_req, "pr_msi", 64'(pr_msi), 64'(m_msi));
        chk(pr_data == m_data, m_req, "pr_data", 64'(pr_data), 64'(m_data));
        chk(pr_tag == m_tag, m_req, "pr_tag", 64'(pr_tag), 64'(m_tag));
      end
      chk(sc_valid == m_sv, "R8", "sc_valid", 64'(sc_valid), 64'(m_sv));
      if (m_sv) begin
        chk(sc_tag == m_stag, "R8", "sc_tag", 64'(sc_tag), 64'(m_stag));
        chk(sc_status == m_sst, m_sreq, "sc_status", 64'(sc_status), 64'(m_sst));
        chk(sc_data == m_sdat, m_sreq, "sc_data", 64'(sc_data), 64'(m_sdat));
      end
      chk(dn_mem_hit == m_mh, "R9", "dn_mem_hit", 64'(dn_mem_hit), 64'(m_mh));
      chk(dn_io_hit == m_ih, "R10", "dn_io_hit", 64'(dn_io_hit), 64'(m_ih));
    end
  end

  // ---------------- stimulus ----------------
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [ADDR_W-1:0] pick_addr();
    case ($urandom_range(6))
      0: return mem_base - 1;
      1: return mem_base;
      2: return mem_limit;
      3: return mem_limit + 1;
      4: return pmem_base;
      5: return pmem_limit + 1;
      default: return $urandom();
    endcase
  endfunction

  function automatic logic [IO_W-1:0] pick_io();
    case ($urandom_range(4))
      0: return io_base - 1;
      1: return io_base;
      2: return io_limit;
      3: return io_limit + 1;
      default: return IO_W'($urandom());
    endcase
  endfunction

  task automatic drive_rq(input bit v);
    rq_valid = v;
    rq_type  = 2'($urandom_range(3));
    rq_msi   = (rq_type == 2'b01) && ($urandom_range(1) == 1);
    rq_addr  = $urandom() | 32'h10;
    rq_be    = BE_W'($urandom()) | 1'b1;
    rq_data  = $urandom();
    rq_tag   = TAG_W'($urandom());
  endtask

  task automatic run(input int n, input int p_v, input int p_pr, input int p_sc, input int p_pc);
    for (int i = 0; i < n; i++) begin
      drive_rq($urandom_range(99) < p_v);
      pr_ready  = ($urandom_range(99) < p_pr);
      sc_ready  = ($urandom_range(99) < p_sc);
      pc_valid  = ($urandom_range(99) < p_pc);
      pc_tag    = TAG_W'($urandom());
      pc_status = ($urandom_range(1) == 1) ? 3'b000 : 3'b001;
      pc_data   = $urandom();
      dn_addr    = pick_addr();
      dn_io_addr = pick_io();
      step();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bme = 0; mae = 0; ioae = 0;
    mem_base = 32'h1000_0000; mem_limit = 32'h1FFF_FFFF;
    pmem_base = 32'h8000_0000; pmem_limit = 32'h8FFF_FFFF;
    io_base = 16'h1000; io_limit = 16'h1FFF;
    dn_addr = 32'h1000_0000; dn_io_addr = 16'h1000;
    drive_rq(0); pr_ready = 1; sc_ready = 1;
    pc_valid = 0; pc_tag = '0; pc_status = 3'b000; pc_data = '0;
    repeat (3) step();
    // R1: nothing valid and no window hits during reset
    chk(!pr_valid && !sc_valid && !dn_mem_hit && !dn_io_hit, "R1", "reset outputs",
        {60'b0, pr_valid, sc_valid, dn_mem_hit, dn_io_hit}, 64'h0);
    rst = 0;
    step();
    chk(!pr_valid && !sc_valid && !dn_mem_hit && !dn_io_hit, "R1", "after reset",
        {60'b0, pr_valid, sc_valid, dn_mem_hit, dn_io_hit}, 64'h0);

    // R2/R3/R4: mastering off, full flow
    run(300, 80, 100, 100, 0);
    // R6: mastering off under primary backpressure, answer queue fills
    run(300, 90, 50, 30, 0);
    // R5/R9/R10: mastering on, windows open
    bme = 1; mae = 1; ioae = 1;
    run(300, 80, 70, 70, 30);
    // R7: completions pass while mastering is off, windows closed
    bme = 0; mae = 0; ioae = 0;
    run(300, 50, 60, 60, 50);
    // R8: build up local answers, then release with primary completions arriving
    sc_ready = 0; pc_valid = 0; pr_ready = 1;
    for (int i = 0; i < 3; i++) begin
      rq_valid = 1; rq_type = 2'b00; rq_msi = 0; rq_tag = TAG_W'(8'h40 + i);
      rq_addr = 32'h1234_5670; rq_be = 4'hF; rq_data = '0;
      step();
    end
    rq_valid = 0;
    step();
    sc_ready = 1;
    for (int i = 0; i < 3; i++) begin
      pc_valid = 1; pc_tag = TAG_W'(8'hA0 + i); pc_status = 3'b000; pc_data = 32'(i);
      step();
    end
    pc_valid = 0;
    repeat (6) step();
    // mixed enables
    mae = 1; ioae = 0; bme = 1;
    run(200, 70, 80, 80, 40);
    mae = 0; ioae = 1; bme = 0;
    run(200, 70, 80, 80, 40);
    drive_rq(0); pc_valid = 0;
    repeat (10) step();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule